// File: doc/BRIEF.md
# Cascadable Unsigned Magnitude Comparator with Minimum Select

This block compares two unsigned operands and reports whether the first is greater than, equal to, or less than the second. The decision is formed by a chain of one-bit cells. The chain starts at the most significant bit pair and ends at bit 0. Each cell receives greater/equal/less flags from the cell above it and passes refined flags to the cell below.

The top cell is fed from three cascade inputs. A stand-alone comparator ties them to greater=0, equal=1, less=0. To compare wider words, the final flags of a more significant slice drive the cascade inputs of the next slice down.

The final less flag also steers a 2:1 selector. The selector outputs the smaller operand, and it outputs B when the operands are equal. The block is purely combinational: it has no clock and no reset.

Top module: `mag_cmp_min`

## Requirements
- R1: With cascade inputs greater=0, equal=1, less=0, `gt_o` is 1 exactly when A > B as unsigned numbers, for example A=8'b0000_1011, B=8'b0000_1001 gives `gt_o`=1, `eq_o`=0, `lt_o`=0.
- R2: With cascade inputs 0/1/0, `lt_o` is 1 exactly when A < B as unsigned numbers.
- R3: With cascade inputs 0/1/0, `eq_o` is 1 exactly when A equals B.
- R4: With cascade inputs 0/1/0, exactly one of `gt_o`, `eq_o`, `lt_o` is 1 for every operand pair.
- R5: `min_o` equals A when `lt_o` is 1 and equals B otherwise, so with cascade inputs 0/1/0 it is the smaller operand and B on a tie.
- R6: With `casc_eq_i`=0, `eq_o` is 0 and `gt_o`/`lt_o` equal `casc_gt_i`/`casc_lt_i`, regardless of the operands.
- R7: With `casc_eq_i`=1, `gt_o` = `casc_gt_i` OR (A > B), `lt_o` = `casc_lt_i` OR (A < B), and `eq_o` = (A == B); a decision from upstream is never cleared.
- R8: The operand width is the parameter `WIDTH` (default 8), and the chain has one cell per bit, ordered from bit WIDTH-1 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A, unsigned |
| b_i | input | WIDTH | Operand B, unsigned |
| casc_gt_i | input | 1 | Upstream "A greater" flag; tie 0 when stand-alone |
| casc_eq_i | input | 1 | Upstream "equal so far" flag; tie 1 when stand-alone |
| casc_lt_i | input | 1 | Upstream "A less" flag; tie 0 when stand-alone |
| gt_o | output | 1 | A greater than B |
| eq_o | output | 1 | A equal to B |
| lt_o | output | 1 | A less than B |
| min_o | output | WIDTH | A when lt_o is 1, else B |

## Verification
Every result is combinational and is due in the same cycle as the operands, with zero clock latency. The bench drives each operand pair just after a rising edge and samples all four outputs at the following falling edge. This leaves half a period for the ripple through all cells to settle, and the outputs are never read at the edge where the inputs change. The bench sweeps every operand pair with the stand-alone cascade. It then sweeps all eight cascade combinations over a set of corner operands, and compares each output against values computed arithmetically in the bench.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } cmp_flags_t;

  localparam cmp_flags_t FLAGS_STANDALONE = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};
endpackage

// File: rtl/cmp_stage.sv
module cmp_stage
  import cmp_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  cmp_flags_t up_i,
  output cmp_flags_t dn_o
);
  timeunit 1ns;
  timeprecision 1ps;

  always_comb begin
    dn_o.gt = up_i.gt | (up_i.eq & a_i & ~b_i);
    dn_o.lt = up_i.lt | (up_i.eq & ~a_i & b_i);
    dn_o.eq = up_i.eq & ~(a_i ^ b_i);
  end

  // an upstream decision survives every cell
  always_comb begin
    if (up_i.gt) a_r7_keep_gt : assert (dn_o.gt);
    if (up_i.lt) a_r7_keep_lt : assert (dn_o.lt);
    if (!up_i.eq) a_r6_no_eq_revive : assert (!dn_o.eq);
  end
endmodule

// File: rtl/cmp_chain.sv
module cmp_chain
  import cmp_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  cmp_flags_t       casc_i,
  output cmp_flags_t       res_o
);
  timeunit 1ns;
  timeprecision 1ps;

  // link[k+1] feeds the cell for bit k; link[WIDTH] is the cascade entry
  cmp_flags_t link [WIDTH+1];

  assign link[WIDTH] = casc_i;

  for (genvar k = WIDTH - 1; k >= 0; k--) begin : g_cell
    cmp_stage u_stage (
      .a_i (a_i[k]),
      .b_i (b_i[k]),
      .up_i(link[k+1]),
      .dn_o(link[k])
    );
  end

  assign res_o = link[0];
endmodule

// File: rtl/min_sel.sv
module min_sel #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             sel_a_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] min_o
);
  timeunit 1ns;
  timeprecision 1ps;

  always_comb min_o = sel_a_i ? a_i : b_i;
endmodule

// File: rtl/mag_cmp_min.sv
module mag_cmp_min
  import cmp_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             casc_gt_i,
  input  logic             casc_eq_i,
  input  logic             casc_lt_i,
  output logic             gt_o,
  output logic             eq_o,
  output logic             lt_o,
  output logic [WIDTH-1:0] min_o
);
  timeunit 1ns;
  timeprecision 1ps;

  cmp_flags_t casc;
  cmp_flags_t res;

  assign casc = '{gt: casc_gt_i, eq: casc_eq_i, lt: casc_lt_i};

  cmp_chain #(.WIDTH(WIDTH)) u_chain (
    .a_i   (a_i),
    .b_i   (b_i),
    .casc_i(casc),
    .res_o (res)
  );

  assign gt_o = res.gt;
  assign eq_o = res.eq;
  assign lt_o = res.lt;

  min_sel #(.WIDTH(WIDTH)) u_min (
    .sel_a_i(res.lt),
    .a_i    (a_i),
    .b_i    (b_i),
    .min_o  (min_o)
  );

  always_comb begin
    if (casc == FLAGS_STANDALONE) begin
      a_r4_one_flag : assert ($countones({gt_o, eq_o, lt_o}) == 1);
      a_r3_eq_match : assert (eq_o == (a_i == b_i));
      a_r5_min_le_a : assert (min_o <= a_i);
      a_r5_min_le_b : assert (min_o <= b_i);
    end
    if (!casc_eq_i) begin
      a_r6_pass_gt : assert (gt_o == casc_gt_i);
      a_r6_pass_lt : assert (lt_o == casc_lt_i);
    end
  end
endmodule

// File: tb/mag_cmp_min_test.sv
module mag_cmp_min_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned W = 8;
  localparam int unsigned MAX_CYCLES = 200000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] a, b, mn;
  logic cgt, ceq, clt, gt, eq, lt;
  int total = 0;
  int bad = 0;
  bit done = 0;

  mag_cmp_min #(.WIDTH(W)) uut (
    .a_i(a), .b_i(b),
    .casc_gt_i(cgt), .casc_eq_i(ceq), .casc_lt_i(clt),
    .gt_o(gt), .eq_o(eq), .lt_o(lt), .min_o(mn)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s a=%0d b=%0d casc=%b%b%b act=%0d exp=%0d", req, a, b, cgt, ceq, clt, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv,
                       input logic g, input logic e, input logic l);
    logic xg, xe, xl;
    @(posedge clk);
    #1;
    a = av; b = bv; cgt = g; ceq = e; clt = l;
    @(negedge clk);
    if (e) begin
      xg = g | (av > bv); xl = l | (av < bv); xe = (av == bv);
    end else begin
      xg = g; xl = l; xe = 1'b0;
    end
    if (!g && e && !l) begin
      // stand-alone: R1 R2 R3 R4 R5
      chk("R1 gt", W'(gt), W'(xg));
      chk("R2 lt", W'(lt), W'(xl));
      chk("R3 eq", W'(eq), W'(xe));
      chk("R4 onehot", W'($countones({gt, eq, lt})), W'(1));
      chk("R5 min", mn, (av < bv) ? av : bv);
    end else begin
      chk(e ? "R7 gt" : "R6 gt", W'(gt), W'(xg));
      chk(e ? "R7 lt" : "R6 lt", W'(lt), W'(xl));
      chk(e ? "R7 eq" : "R6 eq", W'(eq), W'(xe));
      chk("R5 min casc", mn, xl ? av : bv);
    end
  endtask

  function automatic logic [W-1:0] corner(input int i);
    case (i % 8)
      0: return '0;
      1: return '1;
      2: return W'(1);
      3: return {1'b1, {(W-1){1'b0}}};
      4: return {1'b0, {(W-1){1'b1}}};
      5: return W'(i * 37 + 11);
      6: return W'(i * 91 + 5);
      default: return W'(i);
    endcase
  endfunction

  initial begin
    a = '0; b = '0; cgt = 1'b0; ceq = 1'b1; clt = 1'b0;
    // R8: example from bit-serial ordering, decision set at bit 1
    apply(8'b0000_1011, 8'b0000_1001, 1'b0, 1'b1, 1'b0);
    chk("R8 example gt", W'(gt), W'(1));
    chk("R8 example eq", W'(eq), W'(0));
    // R8: MSB decides despite lower bits favouring the other side
    apply(8'b1000_0000, 8'b0111_1111, 1'b0, 1'b1, 1'b0);
    chk("R8 msb wins", W'(gt), W'(1));
    chk("R8 msb min", mn, 8'b0111_1111);
    // exhaustive stand-alone sweep
    for (int i = 0; i < (1 << W); i++)
      for (int j = 0; j < (1 << W); j++)
        apply(W'(i), W'(j), 1'b0, 1'b1, 1'b0);
    // all cascade combinations over corner operands
    for (int c = 0; c < 8; c++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++)
          apply(corner(i), corner(j), c[2], c[1], c[0]);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", MAX_CYCLES, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule